// File: doc/BRIEF.md
# Zero-Common-Mode Three-Level Carrier Modulator

This block drives the three legs of a three-level inverter so that the motor star point never moves relative to the DC-link midpoint. It builds three sinusoidal references that are 120 degrees apart. It compares each of them with one shared triangular carrier, which gives three one-bit comparison results. It then issues, for every phase, the difference of two neighbouring results. Each difference is +1, 0 or -1, so each one is a legal three-level leg state. Because the three differences are taken around a cycle, their sum is zero on every clock. The price is a usable modulation depth of roughly 0.87 of what a direct comparison scheme can reach.

The reference phase advances by a tuning word on each clock, and the amplitude input scales the sine references. The carrier sweeps the full signed reference range. Its half period is a power of two that the carrier-exponent input selects. Dead time, protection and any closed-loop control sit outside this block.

Top module: `cmpwm_modulator`

## Requirements
- R1: Each leg state output uses a 2-bit code: 2'b01 means +1, 2'b00 means 0 and 2'b11 means -1. The code 2'b10 never appears.
- R2: In every clock cycle outside reset, the values of the three leg states add up to zero.
- R3: Let Va, Vb and Vc be 1 when the reference of that phase is strictly greater than the carrier, and 0 otherwise. Then leg A = Va - Vb, leg B = Vb - Vc and leg C = Vc - Va.
- R4: Reference A is round(32767 * sin(theta)) multiplied by amp and shifted right arithmetically by 15 bits. References B and C use the same formula at theta - 120 and theta - 240 degrees. Theta is taken from the top 10 bits of the 32-bit phase, so one step is 360/1024 degrees. The amplitude is unsigned Q1.15, and any value above 16'h8000 is treated as 16'h8000.
- R5: Reset sets the phase to zero. After that, each clock adds the tuning word to the phase, modulo 2^32.
- R6: With exponent e, the carrier is a triangle that starts at -32768 after reset and moves in steps of 2^(16-e). It takes 2^e clocks to rise to +32768 and 2^e clocks to fall back, for a period of 2^(e+1) clocks. An exponent of 0 acts as 1, and an exponent above 16 acts as 16.
- R7: With amplitude zero, all three legs stay at state 0.
- R8: Reset is synchronous and active high. While it is held, and in the first cycle after it is released, all three leg codes read 2'b00.
- R9: With a nonzero tuning word and full amplitude, every leg reaches both +1 and -1 within two fundamental periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_i | input | 16 | Modulation amplitude, unsigned Q1.15, saturated at 1.0 |
| ftw_i | input | PH_W (32) | Tuning word added to the reference phase each clock |
| car_exp_i | input | EW (5) | Carrier half-period exponent |
| st_a_o | output | 2 | Leg A state code |
| st_b_o | output | 2 | Leg B state code |
| st_c_o | output | 2 | Leg C state code |

## Verification
A phase change reaches the leg outputs after four register stages: the table read, the scaling, the comparison and the output register. The carrier takes effect after two stages. None of the checks depends on that exact latency. For static references (tuning word zero), the bench waits several carrier periods after reset. It then counts the +1, 0 and -1 codes on each leg over exactly one carrier period of 2^(e+1) consecutive cycles. Any window of that length holds one full carrier sweep, so the counts match a model that walks one period of its own carrier, whatever the alignment. Reset outputs are sampled while reset is held. The zero-sum and code legality are checked on every falling edge.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

  typedef logic [1:0] lvl3_t;

  localparam lvl3_t LVL_POS = 2'b01;
  localparam lvl3_t LVL_MID = 2'b00;
  localparam lvl3_t LVL_NEG = 2'b11;

  // state for (hi - lo) where hi and lo are comparator bits
  function automatic lvl3_t lvl_from_pair(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return LVL_POS;
      2'b01:   return LVL_NEG;
      default: return LVL_MID;
    endcase
  endfunction

  function automatic int lvl_value(input lvl3_t s);
    case (s)
      LVL_POS: return 1;
      LVL_NEG: return -1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cmpwm_sine_ref.sv
module cmpwm_sine_ref #(
  parameter int DW = 16,
  parameter int QA = 8,
  localparam int IW = QA + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IW-1:0]        idx_i,
  input  logic [DW-1:0]        amp_i,
  output logic signed [DW-1:0] ref_o
);
  localparam int DEPTH = 1 << QA;
  localparam logic signed [DW-1:0] FULL = DW'((1 << (DW-1)) - 1);

  logic signed [DW-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real ang;
      ang = 3.14159265358979 * 0.5 * real'(i) / real'(DEPTH);
      rom[i] = DW'($rtoi(real'(FULL) * $sin(ang) + 0.5));
    end
  end

  logic [1:0]    quad;
  logic [QA-1:0] fine;
  logic [QA-1:0] addr;
  logic          peak;

  always_comb begin
    quad = idx_i[IW-1 -: 2];
    fine = idx_i[QA-1:0];
    addr = quad[0] ? (~fine + QA'(1)) : fine;
    peak = quad[0] && (fine == '0);
  end

  logic signed [DW-1:0] rd_q;
  logic                 peak_q;
  logic                 neg_q;

  always_ff @(posedge clk) begin
    rd_q <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peak_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      peak_q <= peak;
      neg_q  <= quad[1];
    end
  end

  logic signed [DW-1:0]   mag;
  logic signed [DW-1:0]   sgn;
  logic signed [DW:0]     amp_s;
  logic signed [2*DW:0]   prod;

  always_comb begin
    mag   = peak_q ? FULL : rd_q;
    sgn   = neg_q ? -mag : mag;
    amp_s = $signed({1'b0, amp_i});
    prod  = sgn * amp_s;
  end

  always_ff @(posedge clk) begin
    if (rst) ref_o <= '0;
    else     ref_o <= DW'(prod >>> (DW-1));
  end

endmodule

// File: rtl/cmpwm_carrier.sv
module cmpwm_carrier #(
  parameter int DW = 16,
  localparam int EW = $clog2(DW + 1),
  localparam int CW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EW-1:0]        exp_i,
  output logic signed [DW+1:0] car_o
);
  localparam logic signed [DW+1:0] CAR_OFS = (DW+2)'(1 << (DW-1));

  logic [EW-1:0] e_c, e_q;
  logic [CW-1:0] cnt_q, cnt_n, top;
  logic          up_q, up_n;
  logic [CW-1:0] sh;

  always_comb begin
    if (exp_i == '0)           e_c = EW'(1);
    else if (exp_i > EW'(DW))  e_c = EW'(DW);
    else                       e_c = exp_i;
  end

  always_comb begin
    top   = CW'(1) << e_q;
    cnt_n = cnt_q;
    up_n  = up_q;
    if (up_q) begin
      if (cnt_q + CW'(1) >= top) begin
        cnt_n = top;
        up_n  = 1'b0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end else begin
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) up_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      e_q   <= EW'(1);
    end else begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
      e_q   <= e_c;
    end
  end

  always_comb begin
    sh    = cnt_q << (EW'(DW) - e_q);
    car_o = $signed({1'b0, sh}) - CAR_OFS;
  end

endmodule

// File: rtl/cmpwm_leg_combiner.sv
module cmpwm_leg_combiner
  import cmpwm_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NPH = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPH-1:0][DW-1:0]      ref_i,
  input  logic signed [DW+1:0]        car_i,
  output lvl3_t [NPH-1:0]             st_o
);
  logic [NPH-1:0] v_q;

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    localparam int NX = (k + 1) % NPH;
    logic signed [DW+1:0] ref_x;
    assign ref_x = $signed({{2{ref_i[k][DW-1]}}, ref_i[k]});

    always_ff @(posedge clk) begin
      if (rst) v_q[k] <= 1'b0;
      else     v_q[k] <= (ref_x > car_i);
    end

    always_ff @(posedge clk) begin
      if (rst) st_o[k] <= LVL_MID;
      else     st_o[k] <= lvl_from_pair(v_q[k], v_q[NX]);
    end
  end

endmodule

// File: rtl/cmpwm_modulator.sv
module cmpwm_modulator
  import cmpwm_pkg::*;
#(
  parameter int PH_W = 32,
  parameter int DW   = 16,
  parameter int QA   = 8,
  localparam int EW  = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    amp_i,
  input  logic [PH_W-1:0]  ftw_i,
  input  logic [EW-1:0]    car_exp_i,
  output logic [1:0]       st_a_o,
  output logic [1:0]       st_b_o,
  output logic [1:0]       st_c_o
);
  localparam int NPH = 3;
  localparam int IW  = QA + 2;
  localparam logic [PH_W-1:0] THIRD = PH_W'((64'd1 << PH_W) / 3);
  localparam logic [DW-1:0]   AMP_MAX = DW'(1) << (DW-1);

  logic [PH_W-1:0] ph_q;
  logic [DW-1:0]   amp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      amp_q <= '0;
    end else begin
      ph_q  <= ph_q + ftw_i;
      amp_q <= (amp_i > AMP_MAX) ? AMP_MAX : amp_i;
    end
  end

  logic [NPH-1:0][DW-1:0] ref_w;

  for (genvar k = 0; k < NPH; k++) begin : g_ref
    localparam logic [PH_W-1:0] OFS = PH_W'(k) * THIRD;
    logic [IW-1:0] idx;
    logic signed [DW-1:0] r;
    assign idx = IW'((ph_q - OFS) >> (PH_W - IW));

    cmpwm_sine_ref #(.DW(DW), .QA(QA)) u_ref (
      .clk  (clk),
      .rst  (rst),
      .idx_i(idx),
      .amp_i(amp_q),
      .ref_o(r)
    );
    assign ref_w[k] = r;
  end

  logic signed [DW+1:0] car_w;

  cmpwm_carrier #(.DW(DW)) u_car (
    .clk  (clk),
    .rst  (rst),
    .exp_i(car_exp_i),
    .car_o(car_w)
  );

  lvl3_t [NPH-1:0] st_w;

  cmpwm_leg_combiner #(.DW(DW), .NPH(NPH)) u_comb (
    .clk  (clk),
    .rst  (rst),
    .ref_i(ref_w),
    .car_i(car_w),
    .st_o (st_w)
  );

  assign st_a_o = st_w[0];
  assign st_b_o = st_w[1];
  assign st_c_o = st_w[2];

endmodule

// File: rtl/cmpwm_modulator_chk.sv
module cmpwm_modulator_chk
  import cmpwm_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           st_a,
  input logic [1:0]           st_b,
  input logic [1:0]           st_c,
  input logic signed [DW+1:0] car
);
  localparam logic signed [DW+1:0] C_HI = (DW+2)'(1 << (DW-1));
  localparam logic signed [DW+1:0] C_LO = -C_HI;

  // R1
  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    (st_a != 2'b10) && (st_b != 2'b10) && (st_c != 2'b10));

  // R2
  a_r2_sum_zero: assert property (@(posedge clk) disable iff (rst)
    (lvl_value(st_a) + lvl_value(st_b) + lvl_value(st_c)) == 0);

  // R8
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_a == 2'b00) && (st_b == 2'b00) && (st_c == 2'b00));

  // R6
  a_r6_carrier_range: assert property (@(posedge clk) disable iff (rst)
    (car >= C_LO) && (car <= C_HI));

  a_r6_top_turn: assert property (@(posedge clk) disable iff (rst)
    (car == C_HI) |=> (car < C_HI));

  a_r6_bottom_turn: assert property (@(posedge clk) disable iff (rst)
    (car == C_LO) |=> (car > C_LO));

endmodule

bind cmpwm_modulator cmpwm_modulator_chk #(.DW(DW)) u_chk (
  .clk (clk),
  .rst (rst),
  .st_a(st_a_o),
  .st_b(st_b_o),
  .st_c(st_c_o),
  .car (car_w)
);

// File: tb/cmpwm_modulator_test.sv
module cmpwm_modulator_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] amp = '0;
  logic [31:0] ftw = '0;
  logic [4:0]  cexp = 5'd4;
  logic [1:0]  sa, sb, sc;

  int total = 0;
  int bad = 0;
  int mon_bad_sum = 0;
  int mon_bad_code = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmpwm_modulator uut (
    .clk      (clk),
    .rst      (rst),
    .amp_i    (amp),
    .ftw_i    (ftw),
    .car_exp_i(cexp),
    .st_a_o   (sa),
    .st_b_o   (sb),
    .st_c_o   (sc)
  );

  function automatic int dec(input logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b11) return -1;
    return 0;
  endfunction

  // R1 / R2 monitor on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sa == 2'b10 || sb == 2'b10 || sc == 2'b10) mon_bad_code++;
      if (dec(sa) + dec(sb) + dec(sc) != 0) mon_bad_sum++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sa == 2'b00 && sb == 2'b00 && sc == 2'b00, "R8 outputs in reset",
        {26'd0, sa, sb, sc}, 0);
    rst = 1'b0;
  endtask

  // model reference per R4 at a 32-bit phase
  function automatic longint model_ref(input logic [31:0] p, input int a);
    int idx;
    real ang;
    longint s;
    int ae;
    ae = (a > 32768) ? 32768 : a;
    idx = int'(p >> 22);
    ang = 2.0 * 3.14159265358979 * real'(idx) / 1024.0;
    if ($sin(ang) >= 0.0) s = longint'($rtoi(32767.0 * $sin(ang) + 0.5));
    else                  s = -longint'($rtoi(-32767.0 * $sin(ang) + 0.5));
    return (s * longint'(ae)) >>> 15;
  endfunction

  // static references: count codes over one carrier period and compare
  task automatic t_static(input int a, input int e, input string tag);
    int ee, top, per, step;
    longint r [3];
    int ep [3], ez [3], en [3];
    int op [3], oz [3], on [3];
    logic [31:0] third;
    third = 32'd1431655765;
    ee = (e == 0) ? 1 : (e > 16 ? 16 : e);
    top = 1 << ee;
    per = 2 * top;
    step = 65536 >> ee;
    ftw = '0;
    amp = a[15:0];
    cexp = e[4:0];
    do_reset();
    for (int k = 0; k < 3; k++) begin
      r[k] = model_ref(32'd0 - 32'(k) * third, a);
      ep[k] = 0; ez[k] = 0; en[k] = 0;
      op[k] = 0; oz[k] = 0; on[k] = 0;
    end
    for (int i = 0; i < per; i++) begin
      longint c;
      int v [3];
      int cnt;
      cnt = (i < top) ? i : 2 * top - i;
      c = longint'(cnt) * step - 32768;
      for (int k = 0; k < 3; k++) v[k] = (r[k] > c) ? 1 : 0;
      for (int k = 0; k < 3; k++) begin
        int d;
        d = v[k] - v[(k + 1) % 3];
        if (d > 0) ep[k]++; else if (d < 0) en[k]++; else ez[k]++;
      end
    end
    repeat (3 * per + 16) @(posedge clk);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        logic [1:0] s;
        s = (k == 0) ? sa : (k == 1) ? sb : sc;
        if (dec(s) > 0) op[k]++; else if (dec(s) < 0) on[k]++; else oz[k]++;
      end
    end
    for (int k = 0; k < 3; k++) begin
      chk(op[k] == ep[k], $sformatf("%s leg%0d +1 count (R3 R1)", tag, k), op[k], ep[k]);
      chk(on[k] == en[k], $sformatf("%s leg%0d -1 count (R3 R1)", tag, k), on[k], en[k]);
      chk(oz[k] == ez[k], $sformatf("%s leg%0d 0 count (R3)", tag, k), oz[k], ez[k]);
    end
  endtask

  task automatic t_zero_amp();
    int nz;
    nz = 0;
    ftw = 32'h0040_0000;
    amp = '0;
    cexp = 5'd4;
    do_reset();
    repeat (2000) begin
      @(negedge clk);
      if (sa != 2'b00 || sb != 2'b00 || sc != 2'b00) nz++;
    end
    chk(nz == 0, "R7 zero amplitude keeps legs at 0", nz, 0);
  endtask

  task automatic t_running();
    int seen_p [3], seen_n [3];
    ftw = 32'h0040_0000;   // fundamental period 1024 clocks (R5)
    amp = 16'h8000;
    cexp = 5'd3;
    do_reset();
    for (int k = 0; k < 3; k++) begin seen_p[k] = 0; seen_n[k] = 0; end
    repeat (2048) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        logic [1:0] s;
        s = (k == 0) ? sa : (k == 1) ? sb : sc;
        if (dec(s) > 0) seen_p[k]++;
        if (dec(s) < 0) seen_n[k]++;
      end
    end
    for (int k = 0; k < 3; k++) begin
      chk(seen_p[k] > 0, $sformatf("R9 R5 leg%0d reaches +1", k), seen_p[k], 1);
      chk(seen_n[k] > 0, $sformatf("R9 R5 leg%0d reaches -1", k), seen_n[k], 1);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_static(32768, 4, "R3 full amp e4");
    t_static(16384, 5, "R4 half amp e5");
    t_static(8192, 5, "R4 quarter amp e5");
    t_static(40000, 4, "R4 amp saturation");
    t_static(32768, 3, "R6 e3");
    t_static(32768, 0, "R6 exponent 0 clamp");
    t_static(0, 4, "R7 static zero amp");
    t_zero_amp();
    t_running();
    chk(mon_bad_code == 0, "R1 no illegal 2'b10 code", mon_bad_code, 0);
    chk(mon_bad_sum == 0, "R2 leg sum zero every cycle", mon_bad_sum, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule